// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between a byte-wide host write port and the program and mode logic of a parallel NOR flash model. It watches every accepted write for the three-cycle unlock-and-command pattern. The first cycle writes 0xAA to the first unlock address. The second writes 0x55 to the second unlock address. The third write goes to the first unlock address, and its data byte is the command. Writes that form no part of such a pattern leave the block on a data-write output. The program-buffer logic downstream consumes them.

A recognised command byte is presented on a separate command strobe for a mode controller. When a pattern breaks off after one or two unlock cycles, the bytes already swallowed are not lost. They are replayed as ordinary data writes, oldest first, and the write that broke the pattern follows them. The replay leaves through a small queue at one write per clock. While that queue holds entries, the input port deasserts its ready signal. Both unlock addresses arrive on configuration inputs, and each incoming address is reduced to the device size before any comparison.

Top module: `flash_unlock_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle and discards any queued replay writes. After that edge wr_ready_o is 1 and both dat_valid_o and cmd_valid_o are 0.
- R2: In idle, an accepted write that does not start a sequence appears once on the data-write outputs in the next cycle, with the same data byte and the reduced address.
- R3: In idle, an accepted write of 0xAA to the first unlock address produces no output and moves the block to the first-unlock state.
- R4: In the first-unlock state, an accepted write of 0x55 to the second unlock address produces no output and moves the block to the second-unlock state.
- R5: In the first-unlock state, any other accepted write produces two data writes on consecutive cycles. The first is 0xAA at the first unlock address and the second is the current write. The block then returns to idle.
- R6: In the second-unlock state, an accepted write to the first unlock address raises cmd_valid_o for one cycle in the next cycle, with its data byte on cmd_byte_o, and emits no data write. This holds for any data value, 0xAA included. The block then returns to idle.
- R7: In the second-unlock state, a write to any other address produces three data writes on consecutive cycles. They are 0xAA at the first unlock address, then 0x55 at the second unlock address, then the current write. The block then returns to idle.
- R8: An incoming address is ANDed with 2^DEV_AW - 1 before it is compared with either unlock address, and it leaves on dat_addr_o in that reduced form. Address bits at position DEV_AW and above have no effect.
- R9: wr_ready_o is 0 while replay writes are still queued, and each of those cycles is followed by a data write. A write offered while wr_ready_o is 0 is not accepted and causes no output.
- R10: The unlock addresses are taken from unlock_a_i and unlock_b_i at the time of each write, so changing them moves the sequence to the new addresses.
- R11: dat_valid_o and cmd_valid_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Host write request |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | 8 | Host write data byte |
| wr_ready_o | output | 1 | Host write is accepted when this and wr_valid_i are both 1 |
| unlock_a_i | input | ADDR_W | First unlock address (commonly 0x5555) |
| unlock_b_i | input | ADDR_W | Second unlock address (commonly 0x2AAA) |
| dat_valid_o | output | 1 | Data-write strobe towards the program buffer |
| dat_addr_o | output | ADDR_W | Reduced address of the data write |
| dat_data_o | output | 8 | Data byte of the data write |
| cmd_valid_o | output | 1 | Command strobe towards the mode controller |
| cmd_byte_o | output | 8 | Recognised command byte |

## Verification
The bench runs every three-write sequence drawn from a small alphabet of addresses and data bytes. The alphabet includes unlock addresses with high bits set and 0xAA offered as a second or third byte. It compares the full output stream against an arithmetic model of the requirements. Several broken-off cases are given extra attention. A design that lost or reordered replay bytes, or that put 0x55 ahead of 0xAA, would produce a wrong stream. So would a design that let a stalled write slip in while the queue drains, or that left a gap between replay cycles. A design that compared unreduced addresses would treat a high-bit alias of an unlock address as plain data. Another check asserts reset in the middle of a drain, where a queue that survived reset would keep emitting writes. A final check moves the unlock addresses, where a design with hard-wired constants would miss the command.

// File: rtl/fud_pkg.sv
// Package: shared state encoding and protocol byte values for the
// flash unlock decoder. Assumes a byte-wide data path.
package fud_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE       = 2'd0,
        SEQ_GOT_FIRST  = 2'd1,
        SEQ_GOT_SECOND = 2'd2
    } seq_state_t;

    localparam logic [7:0] UNLOCK_BYTE_1 = 8'hAA;
    localparam logic [7:0] UNLOCK_BYTE_2 = 8'h55;

    // Longest burst one accepted write can produce (two replays + itself)
    localparam int MAX_EMIT = 3;

endpackage

// File: rtl/fud_seq_fsm.sv
// Sequence tracker: holds the unlock progress and, for each accepted write,
// computes the writes to emit (0..3, oldest first) and whether a command
// fires. Assumes the address is already reduced to the device size and that
// accept is only raised when the emit queue is empty.
module fud_seq_fsm
    import fud_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              accept,
    input  logic [ADDR_W-1:0]                 addr_m,
    input  logic [7:0]                        data,
    input  logic [ADDR_W-1:0]                 unlock_a,
    input  logic [ADDR_W-1:0]                 unlock_b,
    output logic [1:0]                        emit_cnt,
    output logic [MAX_EMIT-1:0][ADDR_W+7:0]   emit_words,
    output logic                              cmd_fire,
    output logic [7:0]                        cmd_byte
);

    seq_state_t state_q, state_d;

    logic hit_a;
    logic hit_b;
    assign hit_a = (addr_m == unlock_a);
    assign hit_b = (addr_m == unlock_b);

    // Next state, emitted writes and command decision for the current write
    always_comb begin
        state_d    = state_q;
        emit_cnt   = 2'd0;
        emit_words = '0;
        cmd_fire   = 1'b0;
        cmd_byte   = data;
        if (accept) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (hit_a && data == UNLOCK_BYTE_1) begin
                        state_d = SEQ_GOT_FIRST;
                    end else begin
                        emit_cnt      = 2'd1;
                        emit_words[0] = {addr_m, data};
                    end
                end
                SEQ_GOT_FIRST: begin
                    if (hit_b && data == UNLOCK_BYTE_2) begin
                        state_d = SEQ_GOT_SECOND;
                    end else begin
                        state_d       = SEQ_IDLE;
                        emit_cnt      = 2'd2;
                        emit_words[0] = {unlock_a, UNLOCK_BYTE_1};
                        emit_words[1] = {addr_m, data};
                    end
                end
                SEQ_GOT_SECOND: begin
                    state_d = SEQ_IDLE;
                    if (hit_a) begin
                        cmd_fire = 1'b1;
                    end else begin
                        emit_cnt      = 2'd3;
                        emit_words[0] = {unlock_a, UNLOCK_BYTE_1};
                        emit_words[1] = {unlock_b, UNLOCK_BYTE_2};
                        emit_words[2] = {addr_m, data};
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/fud_emit_q.sv
// Emit queue: on load, the first word leaves in the next cycle and the rest
// wait in DEPTH slots, draining one per clock. busy is high while slots are
// occupied. Assumes load is never raised while busy.
module fud_emit_q #(
    parameter int W     = 24,
    parameter int DEPTH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [1:0]             load_cnt,
    input  logic [DEPTH:0][W-1:0]  load_words,
    output logic                   out_valid,
    output logic [W-1:0]           out_word,
    output logic                   busy
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] slot_q;
    logic [CNT_W-1:0]        cnt_q;

    assign busy = (cnt_q != '0);

    // Output register: first loaded word, else head of queue, else idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (load && load_cnt != 2'd0) begin
            out_valid <= 1'b1;
            out_word  <= load_words[0];
        end else if (busy) begin
            out_valid <= 1'b1;
            out_word  <= slot_q[0];
        end else begin
            out_valid <= 1'b0;
        end
    end

    // Occupancy count of the waiting slots
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (load && load_cnt != 2'd0)     cnt_q <= CNT_W'(load_cnt - 2'd1);
        else if (busy)                         cnt_q <= cnt_q - 1'b1;
    end

    // Slot storage: each slot loads its word or shifts towards the head
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (load) begin
                slot_q[i] <= load_words[i+1];
            end else if (busy) begin
                if (i == DEPTH - 1) slot_q[i] <= '0;
                else                slot_q[i] <= slot_q[(i+1) % DEPTH];
            end
        end
    end

endmodule

// File: rtl/flash_unlock_decoder.sv
// Top: reduces incoming addresses to the device size, tracks the unlock
// sequence, routes plain and replayed writes through the emit queue and
// registers command strobes. Assumes DEV_AW <= ADDR_W.
module flash_unlock_decoder
    import fud_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEV_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              wr_ready_o,
    input  logic [ADDR_W-1:0] unlock_a_i,
    input  logic [ADDR_W-1:0] unlock_b_i,
    output logic              dat_valid_o,
    output logic [ADDR_W-1:0] dat_addr_o,
    output logic [7:0]        dat_data_o,
    output logic              cmd_valid_o,
    output logic [7:0]        cmd_byte_o
);

    localparam int               WORD_W    = ADDR_W + 8;
    localparam int               QDEPTH    = MAX_EMIT - 1;
    localparam logic [ADDR_W-1:0] SIZE_MASK = ~({ADDR_W{1'b1}} << DEV_AW);

    logic                            busy;
    logic                            accept;
    logic [ADDR_W-1:0]               addr_m;
    logic [1:0]                      emit_cnt;
    logic [MAX_EMIT-1:0][WORD_W-1:0] emit_words;
    logic                            cmd_fire;
    logic [7:0]                      cmd_byte;
    logic [WORD_W-1:0]               out_word;

    assign addr_m     = wr_addr_i & SIZE_MASK;
    assign accept     = wr_valid_i && !busy;
    assign wr_ready_o = !busy;

    fud_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr_m     (addr_m),
        .data       (wr_data_i),
        .unlock_a   (unlock_a_i),
        .unlock_b   (unlock_b_i),
        .emit_cnt   (emit_cnt),
        .emit_words (emit_words),
        .cmd_fire   (cmd_fire),
        .cmd_byte   (cmd_byte)
    );

    fud_emit_q #(
        .W     (WORD_W),
        .DEPTH (QDEPTH)
    ) emitq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_cnt   (emit_cnt),
        .load_words (emit_words),
        .out_valid  (dat_valid_o),
        .out_word   (out_word),
        .busy       (busy)
    );

    assign dat_addr_o = out_word[WORD_W-1:8];
    assign dat_data_o = out_word[7:0];

    // Command strobe register: one-cycle pulse per recognised command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_byte_o  <= '0;
        end else begin
            cmd_valid_o <= cmd_fire;
            if (cmd_fire) cmd_byte_o <= cmd_byte;
        end
    end

endmodule

// File: rtl/fud_checker.sv
// Checker: temporal properties of the decoder's port behaviour, attached
// to every instance of the top module by the bind below.
module fud_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid_i,
    input logic wr_ready_o,
    input logic dat_valid_o,
    input logic cmd_valid_o
);

    // R11: the two strobes never coincide
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_valid_o && cmd_valid_o));

    // R1: first cycle out of reset is quiet and ready
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dat_valid_o && !cmd_valid_o && wr_ready_o));

    // R9: a stalled cycle is always followed by a replay write
    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready_o |=> dat_valid_o);

    // R6: a command only follows an accepted write
    assert_cmd_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(wr_valid_i && wr_ready_o));

    // R2: a data write follows an accepted write or a pending replay
    assert_dat_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid_o |-> $past((wr_valid_i && wr_ready_o) || !wr_ready_o));

endmodule

bind flash_unlock_decoder fud_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .dat_valid_o (dat_valid_o),
    .cmd_valid_o (cmd_valid_o)
);

// File: tb/flash_unlock_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_unlock_decoder_tb_top;

    localparam int AW = 16;
    localparam int DW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [7:0]    wr_data_i = '0;
    logic          wr_ready_o;
    logic [AW-1:0] unlock_a_i = 16'h5555;
    logic [AW-1:0] unlock_b_i = 16'h2AAA;
    logic          dat_valid_o;
    logic [AW-1:0] dat_addr_o;
    logic [7:0]    dat_data_o;
    logic          cmd_valid_o;
    logic [7:0]    cmd_byte_o;

    always #10 clk = ~clk;

    flash_unlock_decoder #(.ADDR_W(AW), .DEV_AW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o), .unlock_a_i(unlock_a_i),
        .unlock_b_i(unlock_b_i), .dat_valid_o(dat_valid_o), .dat_addr_o(dat_addr_o),
        .dat_data_o(dat_data_o), .cmd_valid_o(cmd_valid_o), .cmd_byte_o(cmd_byte_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // event log: {kind, addr, data}; kind 1 = command
    logic [24:0] act_e [0:15];
    int          act_t [0:15];
    int          act_n = 0;
    logic [24:0] exp_e [0:15];
    int          exp_n = 0;
    int          cyc = 0;
    int          m_state = 0;

    // Monitor: samples registered outputs at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && dat_valid_o && act_n < 16) begin
            act_e[act_n] = {1'b0, dat_addr_o, dat_data_o};
            act_t[act_n] = cyc; act_n++;
        end
        if (rst_n && cmd_valid_o && act_n < 16) begin
            act_e[act_n] = {1'b1, 16'h0000, cmd_byte_o};
            act_t[act_n] = cyc; act_n++;
        end
    end

    task automatic push_exp(input logic k, input logic [15:0] a, input logic [7:0] d);
        exp_e[exp_n] = {k, a, d}; exp_n++;
    endtask

    // Arithmetic model of R2..R8 for one accepted write
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] am;
        am = a & 16'h7FFF;
        case (m_state)
            0: if (d == 8'hAA && am == unlock_a_i) m_state = 1;
               else push_exp(1'b0, am, d);
            1: if (d == 8'h55 && am == unlock_b_i) m_state = 2;
               else begin
                   push_exp(1'b0, unlock_a_i, 8'hAA); push_exp(1'b0, am, d); m_state = 0;
               end
            default: begin
                if (am == unlock_a_i) push_exp(1'b1, 16'h0000, d);
                else begin
                    push_exp(1'b0, unlock_a_i, 8'hAA); push_exp(1'b0, unlock_b_i, 8'h55);
                    push_exp(1'b0, am, d);
                end
                m_state = 0;
            end
        endcase
    endtask

    task automatic send(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!wr_ready_o) @(negedge clk);
        wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        model_write(a, d);
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; act_n = 0; exp_n = 0; m_state = 0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drain outputs, compare the log with the model, then clear both
    task automatic compare(input string req);
        bit ok;
        repeat (6) @(negedge clk);
        ok = (act_n == exp_n);
        for (int i = 0; i < 16; i++)
            if (i < exp_n && i < act_n && act_e[i] != exp_e[i]) ok = 0;
        check(ok, req, "stream", (act_n > 0) ? 32'(act_e[0]) : 32'hDEAD,
              (exp_n > 0) ? 32'(exp_e[0]) : 32'hDEAD);
        if (!ok)
            for (int i = 0; i < 16; i++)
                if (i < exp_n || i < act_n)
                    $display("  entry %0d act=%h exp=%h", i, act_e[i], exp_e[i]);
        act_n = 0; exp_n = 0;
    endtask

    task automatic check_back_to_back(input string req, input int n);
        bit ok;
        ok = (act_n >= n);
        for (int i = 1; i < 16; i++)
            if (i < n && i < act_n && act_t[i] != act_t[i-1] + 1) ok = 0;
        check(ok, req, "consecutive", 32'(act_n), 32'(n));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #3800000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    logic [15:0] sw_a [0:3];
    logic [7:0]  sw_d [0:3];

    initial begin
        sw_a[0] = 16'h5555; sw_a[1] = 16'hAAAA; sw_a[2] = 16'h1234; sw_a[3] = 16'hD555;
        sw_d[0] = 8'hAA;    sw_d[1] = 8'h55;    sw_d[2] = 8'h10;    sw_d[3] = 8'h3C;

        do_reset();
        @(negedge clk);
        // R1: reset state
        check(wr_ready_o == 1'b1, "R1", "ready after reset", 32'(wr_ready_o), 1);
        check(!dat_valid_o && !cmd_valid_o, "R1", "strobes after reset",
              {30'd0, dat_valid_o, cmd_valid_o}, 0);

        // R2: plain write passes through
        send(16'h1234, 8'h3C); compare("R2");

        // R3, R4, R6: unlock cycles silent, command strobed
        send(16'h5555, 8'hAA); repeat (3) @(negedge clk);
        check(act_n == 0, "R3", "no output after first unlock", 32'(act_n), 0);
        send(16'h2AAA, 8'h55); repeat (3) @(negedge clk);
        check(act_n == 0, "R4", "no output after second unlock", 32'(act_n), 0);
        send(16'h5555, 8'h80); compare("R6");

        // R5: break after first unlock
        send(16'h5555, 8'hAA); send(16'h0100, 8'h77);
        repeat (6) @(negedge clk);
        check_back_to_back("R5", 2); compare("R5");

        // R7: break after second unlock, then idle confirmed
        send(16'h5555, 8'hAA); send(16'h2AAA, 8'h55); send(16'h0300, 8'h99);
        repeat (6) @(negedge clk);
        check_back_to_back("R7", 3); compare("R7");
        send(16'h5555, 8'h01); compare("R7");

        // R8: high address bit ignored for matching and output
        send(16'hD555, 8'hAA); send(16'hAAAA, 8'h55); send(16'hD555, 8'h10); compare("R8");
        send(16'hF000, 8'h42); compare("R8");

        // R9: stalled write held during the drain is ignored
        send(16'h5555, 8'hAA); send(16'h2AAA, 8'h55);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_addr_i = 16'h0300; wr_data_i = 8'h99;
        model_write(16'h0300, 8'h99);
        @(negedge clk);
        check(!wr_ready_o, "R9", "ready during drain", 32'(wr_ready_o), 0);
        wr_addr_i = 16'h0444; wr_data_i = 8'hEE;
        @(negedge clk);
        check(!wr_ready_o, "R9", "ready during drain", 32'(wr_ready_o), 0);
        @(negedge clk);
        check(wr_ready_o, "R9", "ready after drain", 32'(wr_ready_o), 1);
        wr_valid_i = 1'b0;
        compare("R9");

        // R10: moved unlock addresses
        unlock_a_i = 16'h0100; unlock_b_i = 16'h0200;
        send(16'h5555, 8'hAA); compare("R10");
        send(16'h0100, 8'hAA); send(16'h0200, 8'h55); send(16'h0100, 8'h30); compare("R10");
        unlock_a_i = 16'h5555; unlock_b_i = 16'h2AAA;

        // R1: reset in the middle of a replay drain
        send(16'h5555, 8'hAA); send(16'h2AAA, 8'h55);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_addr_i = 16'h0300; wr_data_i = 8'h99;
        @(negedge clk);
        wr_valid_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; act_n = 0; exp_n = 0; m_state = 0;
        @(negedge clk);
        check(wr_ready_o, "R1", "ready after mid-drain reset", 32'(wr_ready_o), 1);
        repeat (4) @(negedge clk);
        check(act_n == 0, "R1", "queue cleared by reset", 32'(act_n), 0);

        // Sweep of all three-write sequences over the alphabet (R2/R5/R7/R8)
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 16; k++) begin
                    do_reset();
                    send(sw_a[i / 4], sw_d[i % 4]);
                    send(sw_a[j / 4], sw_d[j % 4]);
                    send(sw_a[k / 4], sw_d[k % 4]);
                    compare("R2/R5/R7/R8 sweep");
                end

        finish_run();
    end

endmodule